// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block is a single-way cache with write-back policy that sits in front of a slower storage level. Both sides use the same request protocol. A requester holds a request, tagged with its ID, for as many cycles as needed, and each cycle it receives done or not-done. The first ID seen while the cache is idle owns the cache until its transaction completes. The cache holds 2^INDEX_BITS sets of four words. Each set keeps a tag, a valid bit and a dirty bit next to its line data.

A request that misses first writes back the victim line if it is dirty. It then fetches the requested line. Only after that does the hit-delay countdown start. Upstream writes change only the cached line. The lower level sees modified data only when that line is evicted. A combinational debug port shows the contents of any set without delay. The downstream port has the same shape as the upstream line interface, so one instance can serve as the lower level of another.

The controller has four states. FREE means no owner. EVICT writes back a dirty victim. FETCH reads the missing line. COUNT runs the hit delay.

The transitions, each taken only in a cycle where the owner presents its request:
- FREE→EVICT on a miss to a dirty set.
- FREE→FETCH on a miss to a clean or invalid set.
- FREE→COUNT on a hit with a nonzero count.
- EVICT→FETCH when the lower level answers done.
- FETCH→COUNT when the lower level answers done.
- COUNT→FREE when the counter is zero. The request completes in that cycle.

A hit with the counter at zero completes in FREE itself.

Top module: `wb_dm_cache`

## Requirements
- R1: After reset every set is invalid and clean, `up_done` and `dn_req` are low, and the hit counter holds HIT_DELAY.
- R2: The address splits into offset = bits [1:0], index = the next INDEX_BITS bits, and tag = the remaining upper bits. Line word k sits at bits [32k+31:32k] of a line bus.
- R3: While one ID owns the cache, a request from any other ID gets not-done and changes no state. The owner's progress counts only its own cycles.
- R4: A miss to an invalid or clean set reads the line from the lower level at {tag, index, 00}. With lower delay M and hit delay C, the request sees M+C+1 not-done cycles and then done.
- R5: A hit sees C not-done cycles and then done.
- R6: A miss to a dirty set first writes the stored line to {stored tag, index, 00}, then fetches. The request sees 2M+C+2 not-done cycles.
- R7: A word write or line write changes only the cached line and marks the set dirty. No downstream write happens until that line is evicted.
- R8: A fetched line is installed with the new tag, valid and clean.
- R9: In the done cycle, `up_rword` carries the addressed word and `up_rline` carries the whole line.
- R10: A downstream request keeps the same address and type until the lower level answers done. Only one is outstanding at a time.
- R11: The debug outputs reflect the set chosen by `dbg_index` in the same cycle.
- R12: After done the counter reloads and the cache returns to FREE, so any ID may take it next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_valid | input | 1 | Upstream request present |
| up_id | input | ID_W | Requester ID |
| up_wr | input | 1 | 1 = write, 0 = read |
| up_is_line | input | 1 | 1 = whole line, 0 = single word |
| up_addr | input | ADDR_BITS | Word address |
| up_wword | input | WORD_W | Write word |
| up_wline | input | 4*WORD_W | Write line |
| up_done | output | 1 | Request completes this cycle |
| up_rword | output | WORD_W | Read word |
| up_rline | output | 4*WORD_W | Read line |
| dn_req | output | 1 | Downstream line request |
| dn_id | output | ID_W | ID this cache presents downstream |
| dn_wr | output | 1 | 1 = line write-back, 0 = line fetch |
| dn_addr | output | ADDR_BITS | Downstream line address (offset zero) |
| dn_wline | output | 4*WORD_W | Victim line data |
| dn_done | input | 1 | Lower level completes this cycle |
| dn_rline | input | 4*WORD_W | Fetched line data |
| dbg_index | input | INDEX_BITS | Set to view |
| dbg_valid | output | 1 | Viewed set valid |
| dbg_dirty | output | 1 | Viewed set dirty |
| dbg_tag | output | ADDR_BITS-INDEX_BITS-2 | Viewed set tag |
| dbg_line | output | 4*WORD_W | Viewed set data |

## Verification
The assertions rely on the owner keeping its address, type and data steady from its first cycle until done. They also rely on the lower level keeping `dn_rline` valid while `dn_done` is high. The stimulus drives each request unchanged until done before starting the next. When it interleaves a foreign ID, the owner's fields are restored exactly afterwards. The bench's lower-level model answers only after M held request cycles and serves reads from its own array.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
    localparam int WBC_OFF_BITS   = 2;
    localparam int WBC_LINE_WORDS = 4;

    typedef enum logic [1:0] {
        PH_FREE  = 2'd0,
        PH_EVICT = 2'd1,
        PH_FETCH = 2'd2,
        PH_COUNT = 2'd3
    } wbc_phase_e;
endpackage

// File: rtl/wbc_set_store.sv
module wbc_set_store #(
    parameter int INDEX_BITS = 3,
    parameter int TAG_W      = 11,
    parameter int WORD_W     = 32,
    parameter int LINE_W     = 128
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [INDEX_BITS-1:0] idx,
    input  logic [INDEX_BITS-1:0] dbg_idx,
    input  logic                  fill_en,
    input  logic [TAG_W-1:0]      fill_tag,
    input  logic [LINE_W-1:0]     fill_line,
    input  logic                  clean_en,
    input  logic                  word_en,
    input  logic [1:0]            word_off,
    input  logic [WORD_W-1:0]     word_data,
    input  logic                  line_en,
    input  logic [LINE_W-1:0]     line_data,
    output logic                  cur_valid,
    output logic                  cur_dirty,
    output logic [TAG_W-1:0]      cur_tag,
    output logic [LINE_W-1:0]     cur_line,
    output logic                  dbg_valid,
    output logic                  dbg_dirty,
    output logic [TAG_W-1:0]      dbg_tag,
    output logic [LINE_W-1:0]     dbg_line
);
    localparam int SETS = 1 << INDEX_BITS;

    logic [SETS-1:0]   valid_v;
    logic [SETS-1:0]   dirty_v;
    logic [TAG_W-1:0]  tag_a  [SETS];
    logic [LINE_W-1:0] line_a [SETS];

    for (genvar g = 0; g < SETS; g++) begin : g_set
        logic              sel;
        logic              valid_r;
        logic              dirty_r;
        logic [TAG_W-1:0]  tag_r;
        logic [LINE_W-1:0] line_r;

        assign sel = (idx == INDEX_BITS'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_r <= 1'b0;
                dirty_r <= 1'b0;
            end else if (sel) begin
                if (fill_en) begin
                    valid_r <= 1'b1;
                    dirty_r <= 1'b0;
                end else if (clean_en) begin
                    dirty_r <= 1'b0;
                end else if (word_en || line_en) begin
                    dirty_r <= 1'b1;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (sel && fill_en) begin
                tag_r  <= fill_tag;
                line_r <= fill_line;
            end else if (sel && line_en) begin
                line_r <= line_data;
            end else if (sel && word_en) begin
                line_r[word_off*WORD_W +: WORD_W] <= word_data;
            end
        end

        assign valid_v[g] = valid_r;
        assign dirty_v[g] = dirty_r;
        assign tag_a[g]   = tag_r;
        assign line_a[g]  = line_r;
    end

    assign cur_valid = valid_v[idx];
    assign cur_dirty = dirty_v[idx];
    assign cur_tag   = tag_a[idx];
    assign cur_line  = line_a[idx];
    assign dbg_valid = valid_v[dbg_idx];
    assign dbg_dirty = dirty_v[dbg_idx];
    assign dbg_tag   = tag_a[dbg_idx];
    assign dbg_line  = line_a[dbg_idx];
endmodule

// File: rtl/wbc_ctrl.sv
module wbc_ctrl
    import wbc_pkg::*;
#(
    parameter int ID_W      = 4,
    parameter int HIT_DELAY = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            up_valid,
    input  logic [ID_W-1:0] up_id,
    input  logic            hit,
    input  logic            victim_dirty,
    input  logic            dn_done,
    output logic            up_done,
    output logic            dn_req,
    output logic            dn_wr,
    output logic            fill_en,
    output logic            clean_en,
    output wbc_phase_e      st_q,
    output logic [ID_W-1:0] owner_q
);
    localparam int CNT_W = (HIT_DELAY < 1) ? 1 : $clog2(HIT_DELAY + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HIT_DELAY);

    wbc_phase_e       ph, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic             active;

    assign active = up_valid && ((st_q == PH_FREE) || (up_id == owner_q));

    // effective phase: lookup decides only in FREE
    always_comb begin
        unique case (st_q)
            PH_FREE:  ph = !hit ? (victim_dirty ? PH_EVICT : PH_FETCH) : PH_COUNT;
            default:  ph = st_q;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (active) begin
            unique case (ph)
                PH_EVICT: st_d = dn_done ? PH_FETCH : PH_EVICT;
                PH_FETCH: st_d = dn_done ? PH_COUNT : PH_FETCH;
                PH_COUNT: st_d = (cnt_q == '0) ? PH_FREE : PH_COUNT;
                PH_FREE:  st_d = PH_FREE;
            endcase
        end
    end

    // state register, hit counter and owner
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= PH_FREE;
            cnt_q   <= CNT_LOAD;
            owner_q <= '0;
        end else begin
            st_q <= st_d;
            if (active && ph == PH_COUNT)
                cnt_q <= (cnt_q == '0) ? CNT_LOAD : cnt_q - 1'b1;
            if (active && st_q == PH_FREE)
                owner_q <= up_id;
        end
    end

    // outputs
    always_comb begin
        dn_req   = active && (ph == PH_EVICT || ph == PH_FETCH);
        dn_wr    = active && (ph == PH_EVICT);
        clean_en = dn_req && dn_wr && dn_done;
        fill_en  = dn_req && !dn_wr && dn_done;
        up_done  = active && (ph == PH_COUNT) && (cnt_q == '0);
    end
endmodule

// File: rtl/wb_dm_cache.sv
module wb_dm_cache
    import wbc_pkg::*;
#(
    parameter int ADDR_BITS  = 16,
    parameter int INDEX_BITS = 3,
    parameter int WORD_W     = 32,
    parameter int ID_W       = 4,
    parameter int HIT_DELAY  = 2,
    parameter int DN_ID      = 15
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        up_valid,
    input  logic [ID_W-1:0]                             up_id,
    input  logic                                        up_wr,
    input  logic                                        up_is_line,
    input  logic [ADDR_BITS-1:0]                        up_addr,
    input  logic [WORD_W-1:0]                           up_wword,
    input  logic [WBC_LINE_WORDS*WORD_W-1:0]            up_wline,
    output logic                                        up_done,
    output logic [WORD_W-1:0]                           up_rword,
    output logic [WBC_LINE_WORDS*WORD_W-1:0]            up_rline,
    output logic                                        dn_req,
    output logic [ID_W-1:0]                             dn_id,
    output logic                                        dn_wr,
    output logic [ADDR_BITS-1:0]                        dn_addr,
    output logic [WBC_LINE_WORDS*WORD_W-1:0]            dn_wline,
    input  logic                                        dn_done,
    input  logic [WBC_LINE_WORDS*WORD_W-1:0]            dn_rline,
    input  logic [INDEX_BITS-1:0]                       dbg_index,
    output logic                                        dbg_valid,
    output logic                                        dbg_dirty,
    output logic [ADDR_BITS-INDEX_BITS-WBC_OFF_BITS-1:0] dbg_tag,
    output logic [WBC_LINE_WORDS*WORD_W-1:0]            dbg_line
);
    localparam int TAG_W  = ADDR_BITS - INDEX_BITS - WBC_OFF_BITS;
    localparam int LINE_W = WBC_LINE_WORDS * WORD_W;

    logic [WBC_OFF_BITS-1:0] a_off;
    logic [INDEX_BITS-1:0]   a_idx;
    logic [TAG_W-1:0]        a_tag;
    logic                    cur_valid, cur_dirty, hit;
    logic [TAG_W-1:0]        cur_tag;
    logic [LINE_W-1:0]       cur_line;
    logic                    fill_en, clean_en;
    wbc_phase_e              st_w;
    logic [ID_W-1:0]         owner_w;

    assign a_off = up_addr[WBC_OFF_BITS-1:0];
    assign a_idx = up_addr[WBC_OFF_BITS +: INDEX_BITS];
    assign a_tag = up_addr[ADDR_BITS-1 -: TAG_W];
    assign hit   = cur_valid && (cur_tag == a_tag);

    wbc_ctrl #(.ID_W(ID_W), .HIT_DELAY(HIT_DELAY)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_id(up_id),
        .hit(hit), .victim_dirty(cur_valid && cur_dirty), .dn_done(dn_done),
        .up_done(up_done), .dn_req(dn_req), .dn_wr(dn_wr),
        .fill_en(fill_en), .clean_en(clean_en), .st_q(st_w), .owner_q(owner_w)
    );

    wbc_set_store #(.INDEX_BITS(INDEX_BITS), .TAG_W(TAG_W), .WORD_W(WORD_W), .LINE_W(LINE_W)) store_i (
        .clk(clk), .rst_n(rst_n), .idx(a_idx), .dbg_idx(dbg_index),
        .fill_en(fill_en), .fill_tag(a_tag), .fill_line(dn_rline), .clean_en(clean_en),
        .word_en(up_done && up_wr && !up_is_line), .word_off(a_off), .word_data(up_wword),
        .line_en(up_done && up_wr && up_is_line), .line_data(up_wline),
        .cur_valid(cur_valid), .cur_dirty(cur_dirty), .cur_tag(cur_tag), .cur_line(cur_line),
        .dbg_valid(dbg_valid), .dbg_dirty(dbg_dirty), .dbg_tag(dbg_tag), .dbg_line(dbg_line)
    );

    assign dn_id    = ID_W'(DN_ID);
    assign dn_addr  = dn_wr ? {cur_tag, a_idx, {WBC_OFF_BITS{1'b0}}}
                            : {a_tag, a_idx, {WBC_OFF_BITS{1'b0}}};
    assign dn_wline = cur_line;
    assign up_rline = cur_line;
    assign up_rword = cur_line[a_off*WORD_W +: WORD_W];
endmodule

// File: rtl/wb_dm_cache_chk.sv
module wb_dm_cache_chk
    import wbc_pkg::*;
#(
    parameter int ID_W      = 4,
    parameter int ADDR_BITS = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 up_valid,
    input logic [ID_W-1:0]      up_id,
    input logic                 up_done,
    input logic                 dn_req,
    input logic                 dn_wr,
    input logic                 dn_done,
    input logic [ADDR_BITS-1:0] dn_addr,
    input wbc_phase_e           st,
    input logic [ID_W-1:0]      owner
);
    // R3: a foreign ID never completes while the cache is held
    a_r3_foreign_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (st != PH_FREE && up_valid && up_id != owner) |-> !up_done);

    // R4: completion never coincides with an open downstream request
    a_r4_done_no_dn: assert property (@(posedge clk) disable iff (!rst_n)
        up_done |-> !dn_req);

    // R6: after an accepted write-back the next downstream access is a fetch
    a_r6_fetch_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && dn_wr && dn_done) |=> !(dn_req && dn_wr));

    // R10: a pending downstream request keeps its address and type
    a_r10_dn_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && !dn_done) |=> (!dn_req || ($stable(dn_addr) && $stable(dn_wr))));

    // R12: done returns the controller to FREE
    a_r12_release: assert property (@(posedge clk) disable iff (!rst_n)
        up_done |=> (st == PH_FREE));

    // R9: done only answers a present request
    a_r9_done_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        up_done |-> up_valid);
endmodule

bind wb_dm_cache wb_dm_cache_chk #(.ID_W(ID_W), .ADDR_BITS(ADDR_BITS)) chk_i (
    .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_id(up_id), .up_done(up_done),
    .dn_req(dn_req), .dn_wr(dn_wr), .dn_done(dn_done), .dn_addr(dn_addr),
    .st(st_w), .owner(owner_w)
);

// File: tb/wb_dm_cache_tb_top.sv
module wb_dm_cache_tb_top;
    localparam int AB = 10;
    localparam int IB = 3;
    localparam int M  = 3;
    localparam int C  = 2;
    localparam int LW = 128;

    typedef struct packed {
        logic [3:0]  id;
        logic        wr;
        logic        ln;
        logic [9:0]  addr;
        logic [31:0] wword;
        logic [7:0]  waits;
        logic        chk_rd;
        logic [31:0] exp_rd;
    } vec_t;

    // R4 cold miss = M+C+1, R5 hit = C, R6 dirty miss = 2M+C+2
    localparam vec_t VEC [9] = '{
        '{4'd1, 1'b1, 1'b0, 10'h000, 32'h0000_00A1, 8'd6,  1'b0, 32'h0},
        '{4'd2, 1'b0, 1'b0, 10'h000, 32'h0,         8'd2,  1'b1, 32'h0000_00A1},
        '{4'd1, 1'b1, 1'b0, 10'h001, 32'h0000_00B2, 8'd2,  1'b0, 32'h0},
        '{4'd1, 1'b0, 1'b0, 10'h020, 32'h0,         8'd10, 1'b1, 32'h0000_1020},
        '{4'd2, 1'b0, 1'b0, 10'h000, 32'h0,         8'd6,  1'b1, 32'h0000_00A1},
        '{4'd2, 1'b0, 1'b0, 10'h001, 32'h0,         8'd2,  1'b1, 32'h0000_00B2},
        '{4'd3, 1'b1, 1'b1, 10'h044, 32'h0000_00C0, 8'd6,  1'b0, 32'h0},
        '{4'd3, 1'b0, 1'b0, 10'h046, 32'h0,         8'd2,  1'b1, 32'h0000_00C2},
        '{4'd2, 1'b0, 1'b1, 10'h047, 32'h0,         8'd2,  1'b1, 32'h0000_00C3}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           up_valid = 1'b0;
    logic [3:0]     up_id = '0;
    logic           up_wr = 1'b0;
    logic           up_is_line = 1'b0;
    logic [AB-1:0]  up_addr = '0;
    logic [31:0]    up_wword = '0;
    logic [LW-1:0]  up_wline = '0;
    logic           up_done;
    logic [31:0]    up_rword;
    logic [LW-1:0]  up_rline;
    logic           dn_req, dn_wr, dn_done;
    logic [3:0]     dn_id;
    logic [AB-1:0]  dn_addr;
    logic [LW-1:0]  dn_wline, dn_rline;
    logic [IB-1:0]  dbg_index = '0;
    logic           dbg_valid, dbg_dirty;
    logic [AB-IB-3:0] dbg_tag;
    logic [LW-1:0]  dbg_line;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2 clk = ~clk;   // 4 ns period

    wb_dm_cache #(.ADDR_BITS(AB), .INDEX_BITS(IB), .WORD_W(32), .ID_W(4),
                  .HIT_DELAY(C), .DN_ID(15)) dut_i (
        .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_id(up_id), .up_wr(up_wr),
        .up_is_line(up_is_line), .up_addr(up_addr), .up_wword(up_wword), .up_wline(up_wline),
        .up_done(up_done), .up_rword(up_rword), .up_rline(up_rline),
        .dn_req(dn_req), .dn_id(dn_id), .dn_wr(dn_wr), .dn_addr(dn_addr), .dn_wline(dn_wline),
        .dn_done(dn_done), .dn_rline(dn_rline), .dbg_index(dbg_index),
        .dbg_valid(dbg_valid), .dbg_dirty(dbg_dirty), .dbg_tag(dbg_tag), .dbg_line(dbg_line)
    );

    // lower-level model: answers on the (M+1)th held request cycle
    logic [LW-1:0] bmem [256];
    int            mcnt;
    int            wb_cnt;
    logic [AB-1:0] last_wb;

    assign dn_done  = dn_req && (mcnt == M);
    assign dn_rline = bmem[dn_addr[9:2]];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcnt    <= 0;
            wb_cnt  <= 0;
            last_wb <= '0;
            for (int l = 0; l < 256; l++)
                for (int w = 0; w < 4; w++)
                    bmem[l][w*32 +: 32] <= 32'h1000 + l*4 + w;
        end else if (dn_req) begin
            if (dn_done) begin
                mcnt <= 0;
                if (dn_wr) begin
                    bmem[dn_addr[9:2]] <= dn_wline;
                    wb_cnt  <= wb_cnt + 1;
                    last_wb <= dn_addr;
                end
            end else begin
                mcnt <= mcnt + 1;
            end
        end
    end

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d cycles expected<=20000", cyc);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] id, input logic wr, input logic ln,
                         input logic [9:0] addr, input logic [31:0] w);
        up_valid   = 1'b1;
        up_id      = id;
        up_wr      = wr;
        up_is_line = ln;
        up_addr    = addr;
        up_wword   = w;
        up_wline   = {w + 32'd3, w + 32'd2, w + 32'd1, w};
    endtask

    // hold a request until done; return not-done count and read data
    task automatic do_req(input logic [3:0] id, input logic wr, input logic ln,
                          input logic [9:0] addr, input logic [31:0] w,
                          output int waits, output logic [31:0] rd);
        waits = 0;
        rd = '0;
        forever begin
            @(negedge clk);
            drive(id, wr, ln, addr, w);
            #1;
            if (up_done) begin
                rd = ln ? up_rline[addr[1:0]*32 +: 32] : up_rword;
                break;
            end
            waits++;
            if (waits > 200) break;
        end
        @(negedge clk);
        up_valid = 1'b0;
        #1;
    endtask

    initial begin
        int          waits;
        logic [31:0] rd;
        bit          all_inv;

        repeat (3) @(negedge clk);
        // R1: reset state
        #1;
        chk(up_done == 1'b0, "R1 done low in reset", 128'(up_done), 128'd0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(dn_req == 1'b0, "R1 no downstream request", 128'(dn_req), 128'd0);
        all_inv = 1'b1;
        for (int s = 0; s < 8; s++) begin
            dbg_index = IB'(s);
            #0;
            if (dbg_valid || dbg_dirty) all_inv = 1'b0;
        end
        chk(all_inv, "R1 all sets invalid and clean", 128'(all_inv), 128'd1);

        // table walk
        for (int v = 0; v < 9; v++) begin
            if (v == 3) begin
                // R7: nothing written downstream yet, memory word unchanged
                chk(wb_cnt == 0, "R7 no write-through", 128'(wb_cnt), 128'd0);
                chk(bmem[0][31:0] == 32'h1000, "R7 lower memory untouched", 128'(bmem[0][31:0]), 128'h1000);
            end
            do_req(VEC[v].id, VEC[v].wr, VEC[v].ln, VEC[v].addr, VEC[v].wword, waits, rd);
            chk(waits == int'(VEC[v].waits), $sformatf("R4/R5/R6 latency vec%0d", v),
                128'(waits), 128'(VEC[v].waits));
            if (VEC[v].chk_rd)
                chk(rd == VEC[v].exp_rd, $sformatf("R9 read data vec%0d", v), 128'(rd), 128'(VEC[v].exp_rd));
            if (v == 3) begin
                // R6: dirty victim written back to rebuilt address with its data
                chk(wb_cnt == 1, "R6 one write-back", 128'(wb_cnt), 128'd1);
                chk(last_wb == 10'h000, "R6 write-back address", 128'(last_wb), 128'h0);
                chk(bmem[0][63:0] == {32'h0000_00B2, 32'h0000_00A1}, "R6 write-back data",
                    128'(bmem[0][63:0]), 128'h000000B2_000000A1);
            end
            if (v == 4) begin
                // R8: refetched line valid, clean, old tag
                dbg_index = 3'd0; #0;
                chk(dbg_valid && !dbg_dirty && dbg_tag == 5'd0, "R8 installed clean",
                    128'({dbg_valid, dbg_dirty, dbg_tag}), 128'({1'b1, 1'b0, 5'd0}));
            end
        end

        // R11 and R7: debug view of line-written set, same cycle
        dbg_index = 3'd1; #0;
        chk(dbg_valid && dbg_dirty && dbg_tag == 5'd2, "R11 R7 dirty set view",
            128'({dbg_valid, dbg_dirty, dbg_tag}), 128'({1'b1, 1'b1, 5'd2}));
        chk(dbg_line == {32'hC3, 32'hC2, 32'hC1, 32'hC0}, "R11 line view",
            dbg_line, {32'hC3, 32'hC2, 32'hC1, 32'hC0});
        chk(bmem[17] == {32'h1047, 32'h1046, 32'h1045, 32'h1044}, "R7 line write stays in cache",
            bmem[17], {32'h1047, 32'h1046, 32'h1045, 32'h1044});

        // R2: offset selects the word within the line
        dbg_index = 3'd0; #0;
        chk(dbg_line[63:32] == 32'h0000_00B2, "R2 offset 1 maps to bits 63:32",
            128'(dbg_line[63:32]), 128'hB2);

        // R3: ownership lock with a foreign ID interleaved
        waits = 0;
        begin
            bit foreign_ok = 1'b1;
            bit got_done = 1'b0;
            for (int k = 0; k < 2; k++) begin
                @(negedge clk); drive(4'd4, 1'b0, 1'b0, 10'h080, 32'h0); #1;
                if (up_done) got_done = 1'b1; else waits++;
            end
            for (int k = 0; k < 3; k++) begin
                @(negedge clk); drive(4'd5, 1'b0, 1'b0, 10'h080, 32'h0); #1;
                if (up_done || dn_req) foreign_ok = 1'b0;
            end
            chk(foreign_ok, "R3 foreign ID blocked", 128'(foreign_ok), 128'd1);
            while (!got_done && waits < 100) begin
                @(negedge clk); drive(4'd4, 1'b0, 1'b0, 10'h080, 32'h0); #1;
                if (up_done) begin
                    got_done = 1'b1;
                    chk(up_rword == 32'h1080, "R3 owner read data", 128'(up_rword), 128'h1080);
                end else waits++;
            end
            @(negedge clk); up_valid = 1'b0; #1;
            chk(waits == M + C + 1, "R3 owner counts own cycles", 128'(waits), 128'(M + C + 1));
        end

        // R12: released, other ID now hits after C
        do_req(4'd5, 1'b0, 1'b0, 10'h080, 32'h0, waits, rd);
        chk(waits == C, "R12 second ID hits after release", 128'(waits), 128'(C));
        chk(rd == 32'h1080, "R12 second ID data", 128'(rd), 128'h1080);

        // R10: write-back address stays fixed; dirty set 1 evicted by tag 3
        do_req(4'd6, 1'b0, 1'b0, 10'h064, 32'h0, waits, rd);
        chk(last_wb == 10'h044, "R10 held write-back address", 128'(last_wb), 128'h044);
        chk(waits == 2*M + C + 2, "R6 dirty miss latency", 128'(waits), 128'(2*M + C + 2));

        finish_run();
    end
endmodule